// File: doc/BRIEF.md
# Programmable Presettable Down Counter

This block is a small down counter that is meant to be chained into divide-by-N dividers. It counts down by one on each counting edge and can be loaded with a programmed start value from a parallel preset bus. A clear input forces the count to zero. A hold input can block counting. When the count input is parked high, the hold input becomes a second count input that acts on its falling edge.

A zero flag marks terminal count. A feedback input selects what that flag means. With feedback high, the flag shows that the count is all zeroes. With feedback low, the flag follows the load input, which is how one stage reloads the next in a chain.

The block runs on a fast system clock. The count input and the hold input are asynchronous. Each of them passes through a two-flop synchronizer and then an edge detector, so every edge gives exactly one decrement request one system cycle long. Clear and load are synchronous level overrides that are sampled on each system clock edge. The system reset `rst_n` clears the count and the synchronizer stages.

Top module: `prog_down_counter`

## Requirements
- R1: While clear_i is high, count_o becomes 0 on the next system clock edge, whatever load_i, preset_i, hold_i and cnt_clk_i do.
- R2: While clear_i is high, zero_o is high if chain_fb_i is high. zero_o is low if chain_fb_i and load_i are both low.
- R3: While clear_i is low and load_i is high, count_o takes the value of preset_i on the next system edge, with bit 0 as the least significant bit. Load overrides any pending decrement.
- R4: With clear_i, load_i and hold_i low, a 0-to-1 change on cnt_clk_i lowers count_o by one. The change appears on the third rising system edge after the input changed: two synchronizer flops, then the count register.
- R5: While the synchronized hold_i is high, a rising edge on cnt_clk_i leaves count_o unchanged.
- R6: While the synchronized cnt_clk_i is high, a 1-to-0 change on hold_i lowers count_o by one, with the same three-edge latency as R4.
- R7: A decrement from 0 gives 15 (all ones), so the count wraps modulo 2^WIDTH.
- R8: With chain_fb_i high and clear_i and load_i low, zero_o is high exactly when count_o is 0.
- R9: With chain_fb_i low, zero_o equals load_i.
- R10: With chain_fb_i high, load_i high and clear_i low, zero_o is low. The flag becomes valid again once load_i falls.
- R11: A count edge that is held for many system cycles gives exactly one decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| clear_i | input | 1 | Level override that forces the count to zero |
| load_i | input | 1 | Level override that loads preset_i |
| hold_i | input | 1 | Blocks counting; its falling edge counts while cnt_clk_i is high |
| cnt_clk_i | input | 1 | Asynchronous count input, acts on its rising edge |
| preset_i | input | WIDTH (4) | Programmed start value, bit 0 least significant |
| chain_fb_i | input | 1 | Selects the meaning of the zero flag |
| count_o | output | WIDTH (4) | Current count |
| zero_o | output | 1 | Terminal-count / reload flag |

## Verification
The bench aims at these cases:
- **Long count levels.** It holds the count input high for many cycles. A design that decrements on the level instead of the edge would run the count down several steps.
- **Falling edge on hold.** It drives a hold falling edge while the count input is parked high. A design that ignores the alternate count path would miss that decrement.
- **Hold rising while the count input is high.** A design that reacts to the wrong polarity of hold would count on that rising edge.
- **Wrap from zero to fifteen.** A saturating design would stick at 0.
- **Clear against load and edges.** It applies clear together with load and count edges. A design with the wrong priority would show the preset value or a decremented count.
- **Zero flag in all three feedback cases.** It checks the flag while loading, under clear, and with feedback low. A design with the wrong gating would flag terminal count while the preset is still being applied.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Default counter width and synchronizer depth
    localparam int PDC_WIDTH       = 4;
    localparam int PDC_SYNC_STAGES = 2;

    // Count-register update selected for the current cycle, in priority order
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_LOAD  = 2'd2,
        UPD_STEP  = 2'd3
    } upd_sel_e;

endpackage

// File: rtl/pdc_edge_sync.sv
module pdc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] chain;
        logic         prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[TOP-1:0], async_i};
        end else begin
            st_d.chain = async_i;
        end
        st_d.prev = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[TOP];
    assign rise_o  = st_q.chain[TOP] & ~st_q.prev;
    assign fall_o  = ~st_q.chain[TOP] & st_q.prev;

    // R11: a detected edge lasts exactly one system cycle
    a_r11_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r11_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/pdc_step_gen.sv
module pdc_step_gen (
    input  logic cnt_lvl_i,
    input  logic cnt_rise_i,
    input  logic hold_lvl_i,
    input  logic hold_fall_i,
    output logic step_o
);

    logic main_path;
    logic alt_path;

    always_comb begin
        // Normal counting: rising edge of the count input while hold is low
        main_path = cnt_rise_i & ~hold_lvl_i;
        // Alternate counting: falling edge of hold while the count input is high
        alt_path  = hold_fall_i & cnt_lvl_i;
        step_o    = main_path | alt_path;
    end

endmodule

// File: rtl/pdc_count_core.sv
module pdc_count_core
    import pdc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_t;

    core_t    st_d, st_q;
    upd_sel_e sel;

    always_comb begin
        if (clear_i) begin
            sel = UPD_CLEAR;
        end else if (load_i) begin
            sel = UPD_LOAD;
        end else if (step_i) begin
            sel = UPD_STEP;
        end else begin
            sel = UPD_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (sel)
            UPD_CLEAR: st_d.count = ZERO;
            UPD_LOAD:  st_d.count = preset_i;
            UPD_STEP:  st_d.count = st_q.count - ONE;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == ZERO));
    a_r3_load_takes_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_i) |=> (count_o == $past(preset_i)));
    a_r4_step_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i && step_i) |=> (count_o == $past(count_o) - ONE));
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i && !step_i) |=> $stable(count_o));
    a_r7_wrap_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i && step_i && count_o == ZERO) |=> (&count_o));

endmodule

// File: rtl/pdc_zero_flag.sv
module pdc_zero_flag #(
    parameter int WIDTH = 4
) (
    input  logic             clear_i,
    input  logic             load_i,
    input  logic             chain_fb_i,
    input  logic [WIDTH-1:0] count_i,
    output logic             zero_o
);

    logic at_zero;

    always_comb begin
        at_zero = (count_i == '0);
        if (chain_fb_i) begin
            zero_o = clear_i | (~load_i & at_zero);
        end else begin
            zero_o = load_i;
        end
    end

endmodule

// File: rtl/prog_down_counter.sv
module prog_down_counter
    import pdc_pkg::*;
#(
    parameter int WIDTH       = PDC_WIDTH,
    parameter int SYNC_STAGES = PDC_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic             hold_i,
    input  logic             cnt_clk_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             chain_fb_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);

    logic cnt_lvl, cnt_rise, cnt_fall;
    logic hold_lvl, hold_rise, hold_fall;
    logic step;

    pdc_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cnt_clk_i),
        .level_o (cnt_lvl),
        .rise_o  (cnt_rise),
        .fall_o  (cnt_fall)
    );

    pdc_edge_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hold_i),
        .level_o (hold_lvl),
        .rise_o  (hold_rise),
        .fall_o  (hold_fall)
    );

    pdc_step_gen u_step (
        .cnt_lvl_i   (cnt_lvl),
        .cnt_rise_i  (cnt_rise),
        .hold_lvl_i  (hold_lvl),
        .hold_fall_i (hold_fall),
        .step_o      (step)
    );

    pdc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .load_i   (load_i),
        .preset_i (preset_i),
        .step_i   (step),
        .count_o  (count_o)
    );

    pdc_zero_flag #(.WIDTH(WIDTH)) u_zero (
        .clear_i    (clear_i),
        .load_i     (load_i),
        .chain_fb_i (chain_fb_i),
        .count_i    (count_o),
        .zero_o     (zero_o)
    );

    a_r5_hold_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
        hold_lvl |-> !step);
    a_r5_hold_rise_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rise && !cnt_rise) |-> !step);
    a_r6_fall_low_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_fall && !hold_fall) |-> !step);
    a_r2_clear_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && chain_fb_i) |-> zero_o);
    a_r8_terminal_count: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_fb_i && !clear_i && !load_i && count_o == '0) |-> zero_o);
    a_r10_load_masks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_fb_i && !clear_i && load_i) |-> !zero_o);
    a_r9_flag_tracks_load: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_fb_i |-> (zero_o == load_i));

endmodule

// File: tb/prog_down_counter_bench.sv
module prog_down_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       load_i = 1'b0;
    logic       hold_i = 1'b0;
    logic       cnt_clk_i = 1'b0;
    logic [3:0] preset_i = 4'd0;
    logic       chain_fb_i = 1'b1;
    logic [3:0] count_o;
    logic       zero_o;

    int tests = 0;
    int fails = 0;
    string cur_req = "R8";

    always #4 clk = ~clk;

    prog_down_counter u_prog_down_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .load_i     (load_i),
        .hold_i     (hold_i),
        .cnt_clk_i  (cnt_clk_i),
        .preset_i   (preset_i),
        .chain_fb_i (chain_fb_i),
        .count_o    (count_o),
        .zero_o     (zero_o)
    );

    // Behavioural reference: input histories in queues, count as an integer
    int mcount = 0;
    bit qc[$];
    bit qh[$];
    bit m_lvl, m_prev, m_hlvl, m_hprev, m_step;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcount = 0;
            qc = {1'b0, 1'b0, 1'b0};
            qh = {1'b0, 1'b0, 1'b0};
        end else begin
            m_lvl   = qc[$-1];
            m_prev  = qc[$-2];
            m_hlvl  = qh[$-1];
            m_hprev = qh[$-2];
            m_step  = (m_lvl && !m_prev && !m_hlvl) || (!m_hlvl && m_hprev && m_lvl);
            if (clear_i)     mcount = 0;
            else if (load_i) mcount = int'(preset_i);
            else if (m_step) mcount = (mcount + 15) % 16;
            qc.push_back(cnt_clk_i);
            qh.push_back(hold_i);
            if (qc.size() > 4) void'(qc.pop_front());
            if (qh.size() > 4) void'(qh.pop_front());
        end
    end

    function automatic int exp_zero();
        if (chain_fb_i) return (clear_i || (!load_i && mcount == 0)) ? 1 : 0;
        return load_i ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, int'(count_o), mcount, "count");
            chk(cur_req, int'(zero_o), exp_zero(), "zero flag");
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_cnt();
        cnt_clk_i = 1'b1;
        wait_n(5);
        cnt_clk_i = 1'b0;
        wait_n(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R8", int'(count_o), 0, "reset count");
        chk("R8", int'(zero_o), 1, "reset zero flag");

        // R3 load, with R10 flag masking while loading
        cur_req = "R3";
        preset_i = 4'b1010;
        load_i = 1'b1;
        wait_n(1);
        chk("R3", int'(count_o), 10, "loaded value");
        chk("R10", int'(zero_o), 0, "flag while loading");
        load_i = 1'b0;
        wait_n(1);
        chk("R10", int'(zero_o), 0, "flag after load of nonzero");

        // R4 decrement latency: changes on third edge
        cur_req = "R4";
        cnt_clk_i = 1'b1;
        wait_n(2);
        chk("R4", int'(count_o), 10, "before third edge");
        wait_n(1);
        chk("R4", int'(count_o), 9, "after third edge");
        // R11 long level gives one step
        cur_req = "R11";
        wait_n(20);
        chk("R11", int'(count_o), 9, "held high");
        cnt_clk_i = 1'b0;
        wait_n(5);
        chk("R11", int'(count_o), 9, "falling count edge");
        cur_req = "R4";
        pulse_cnt();
        pulse_cnt();
        chk("R4", int'(count_o), 7, "two pulses");

        // R5 hold blocks counting
        cur_req = "R5";
        hold_i = 1'b1;
        wait_n(4);
        pulse_cnt();
        cnt_clk_i = 1'b1;
        wait_n(6);
        chk("R5", int'(count_o), 7, "blocked by hold");

        // R6 hold falling edge counts while count input high
        cur_req = "R6";
        hold_i = 1'b0;
        wait_n(2);
        chk("R6", int'(count_o), 7, "before alternate edge lands");
        wait_n(1);
        chk("R6", int'(count_o), 6, "alternate edge");
        hold_i = 1'b1;
        wait_n(5);
        chk("R6", int'(count_o), 6, "hold rising does not count");
        hold_i = 1'b0;
        wait_n(5);
        chk("R6", int'(count_o), 5, "second alternate edge");
        cnt_clk_i = 1'b0;
        wait_n(5);

        // R7 wrap and R8 terminal count
        cur_req = "R7";
        preset_i = 4'd1;
        load_i = 1'b1;
        wait_n(1);
        load_i = 1'b0;
        wait_n(1);
        chk("R8", int'(zero_o), 0, "count one");
        pulse_cnt();
        chk("R8", int'(count_o), 0, "reached zero");
        chk("R8", int'(zero_o), 1, "terminal flag");
        pulse_cnt();
        chk("R7", int'(count_o), 15, "wrap");
        chk("R8", int'(zero_o), 0, "flag after wrap");

        // R3 load overrides a pending step
        cur_req = "R3";
        cnt_clk_i = 1'b1;
        wait_n(2);
        preset_i = 4'b0011;
        load_i = 1'b1;
        wait_n(1);
        chk("R3", int'(count_o), 3, "load beats step");
        load_i = 1'b0;
        cnt_clk_i = 1'b0;
        wait_n(5);

        // R9 feedback low: flag follows load
        cur_req = "R9";
        chain_fb_i = 1'b0;
        wait_n(1);
        chk("R9", int'(zero_o), 0, "load low");
        load_i = 1'b1;
        preset_i = 4'd0;
        wait_n(1);
        chk("R9", int'(zero_o), 1, "load high");
        load_i = 1'b0;
        wait_n(1);
        chk("R9", int'(zero_o), 0, "count zero but feedback low");

        // R1 and R2 clear overrides everything
        cur_req = "R1";
        chain_fb_i = 1'b1;
        preset_i = 4'd12;
        load_i = 1'b1;
        wait_n(1);
        load_i = 1'b0;
        wait_n(1);
        clear_i = 1'b1;
        load_i = 1'b1;
        cnt_clk_i = 1'b1;
        wait_n(1);
        chk("R1", int'(count_o), 0, "clear beats load");
        chk("R2", int'(zero_o), 1, "clear with feedback high");
        load_i = 1'b0;
        wait_n(4);
        chk("R1", int'(count_o), 0, "clear beats step");
        chain_fb_i = 1'b0;
        wait_n(1);
        chk("R2", int'(zero_o), 0, "clear with feedback and load low");
        clear_i = 1'b0;
        cnt_clk_i = 1'b0;
        chain_fb_i = 1'b1;
        wait_n(5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule